// File: doc/BRIEF.md
# Per-Channel Edge Delay Scheduler

The block is a digital timing model for one output channel of a pattern-driven pin driver. It receives the rising and falling transitions of the channel's pattern data and of its driver enable, each tagged with the pattern cycle in which it occurs. For each transition it returns the scheduled edge time, in fine steps of about 19.53 ps, measured from the I/O clock origin. One pattern cycle is 256 fine steps, or 5 ns.

Three programmable adjustments shape each edge. A propagation delay is added equally to both polarities. It is made of a calibration portion and a user portion, and their sum is held within 240 steps. A signed offset from -128 to +112 steps moves falling edges only. Data and enable each carry a complete, separate set of these settings. Because the driver only shows data once it is enabled, the block also reports an effective data time: the later of the data edge and the most recent enable-assert edge.

Settings are written through a small configuration port. A write that breaks a limit is refused, and a sticky error flag records it. A falling edge that the offset would place before the preceding rising edge of the same signal is pulled back to that rising edge and flagged as distorted.

Top module: `edge_delay_scheduler`

## Requirements
- R1: After reset, outValid, outDistort and rangeErr are 0, and every calibration, user and offset setting of both signals is 0. A rising edge at cycle c is then timed at c*256.
- R2: An event presented with evValid=1 produces outValid=1 on the following clock, with outIsEnable and outRise repeating evIsEnable and evRise. Without an event, outValid is 0 on the following clock.
- R3: A rising edge at cycle c is timed at c*256 + cal + user, using the settings of its own signal (evIsEnable=0 selects data, 1 selects enable).
- R4: A falling edge at cycle c is timed at c*256 + cal + user + off, where off is the signed offset of its signal. The offset never changes rising-edge times.
- R5: Writes address one signal through cfgChan (0 = data, 1 = enable), and one field through cfgField (0 = calibration delay, 1 = user delay, 2 = falling offset, 3 = no field). A write to one signal leaves the other signal's edge times unchanged.
- R6: A delay write (field 0 or 1) whose resulting cal + user exceeds 240 is refused, sets rangeErr on the next clock, and leaves the earlier value in use. A sum of exactly 240 is accepted.
- R7: An offset write (field 2, cfgData read as signed 8-bit) above +112 is refused in the same way. Values from -128 to +112 are accepted.
- R8: If a falling edge would land earlier than the last rising-edge time of the same signal (taken as 0 before any rise since reset, and including results below 0), its time is set to that rising-edge time and outDistort is 1 for that output.
- R9: For a data edge, outEffTime is the greater of outTime and the last enable rising-edge time (0 before any such edge since reset). For an enable edge, outEffTime equals outTime.
- R10: Edge times are kept modulo 2^32. A falling edge whose exact time reaches 2^32 or more is reported wrapped and is not treated as distorted.
- R11: rangeErr, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgChan | input | 1 | Target signal: 0 data, 1 enable |
| cfgField | input | 2 | Field: 0 calibration, 1 user delay, 2 falling offset, 3 none |
| cfgData | input | 8 | Write value (unsigned for delays, signed for offset) |
| evValid | input | 1 | Edge event present |
| evIsEnable | input | 1 | Event belongs to the enable (1) or data (0) |
| evRise | input | 1 | Event is a rising (1) or falling (0) transition |
| evCycle | input | 24 | Pattern cycle index of the event |
| outValid | output | 1 | Scheduled edge available |
| outIsEnable | output | 1 | Signal of the scheduled edge |
| outRise | output | 1 | Polarity of the scheduled edge |
| outTime | output | 32 | Edge time in fine steps |
| outEffTime | output | 32 | Effective data time after enable gating |
| outDistort | output | 1 | Falling edge was clamped to the preceding rise |
| rangeErr | output | 1 | Sticky flag for a refused write |

## Verification
The assertions assume that every event carries a defined signal and polarity whenever evValid is high. They also assume that outputs are read only in the cycle after an event. The checks on rising-edge slots further rely on the delay sum never passing 240, which the write limit itself enforces. The stimulus drives one event or one write at a time on the falling clock edge and never leaves the event fields undefined. It deliberately includes refused writes, so the range rule is exercised without ever placing an illegal delay in use.

// File: rtl/eds_pkg.sv
package eds_pkg;
  localparam int CYC_W    = 24;
  localparam int FINE_W   = 8;
  localparam int TIME_W   = CYC_W + FINE_W;
  localparam int SET_W    = 8;
  localparam int PROP_MAX = 240;
  localparam int OFF_MAX  = 112;
  localparam int NUM_SIG  = 2;

  typedef struct packed {
    logic capture;
    logic isEnable;
    logic isRise;
  } edgeStrobe_t;

  typedef struct packed {
    logic        [SET_W-1:0] prop;
    logic signed [SET_W-1:0] off;
  } sigDelay_t;
endpackage

// File: rtl/eds_ctrl.sv
module eds_ctrl
  import eds_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic                cfgChan,
  input  logic [1:0]          cfgField,
  input  logic [SET_W-1:0]    cfgData,
  input  logic                evValid,
  input  logic                evIsEnable,
  input  logic                evRise,
  output edgeStrobe_t         strobe,
  output sigDelay_t           delays [NUM_SIG],
  output logic                rangeErr
);
  localparam logic [1:0] FLD_CAL = 2'd0;
  localparam logic [1:0] FLD_USR = 2'd1;
  localparam logic [1:0] FLD_OFF = 2'd2;

  logic [NUM_SIG-1:0] errHit;

  // decode of the incoming event into datapath strobes
  always_comb begin
    strobe.capture  = evValid;
    strobe.isEnable = evIsEnable;
    strobe.isRise   = evRise;
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    logic        [SET_W-1:0] calQ;
    logic        [SET_W-1:0] usrQ;
    logic signed [SET_W-1:0] offQ;
    logic        [SET_W-1:0] calNext;
    logic        [SET_W-1:0] usrNext;
    logic        [SET_W:0]   sumNext;
    logic                    hit;
    logic                    propBad;
    logic                    offBad;

    always_comb begin
      hit     = cfgWr && (cfgChan == s[0]);
      calNext = (cfgField == FLD_CAL) ? cfgData : calQ;
      usrNext = (cfgField == FLD_USR) ? cfgData : usrQ;
      sumNext = {1'b0, calNext} + {1'b0, usrNext};
      propBad = (sumNext > (SET_W+1)'(PROP_MAX));
      offBad  = ($signed(cfgData) > $signed(SET_W'(OFF_MAX)));
      errHit[s] = 1'b0;
      if (hit) begin
        if ((cfgField == FLD_CAL || cfgField == FLD_USR) && propBad)
          errHit[s] = 1'b1;
        else if (cfgField == FLD_OFF && offBad)
          errHit[s] = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        calQ <= '0;
        usrQ <= '0;
        offQ <= '0;
      end else if (hit && !errHit[s]) begin
        case (cfgField)
          FLD_CAL: calQ <= cfgData;
          FLD_USR: usrQ <= cfgData;
          FLD_OFF: offQ <= $signed(cfgData);
          default: ;
        endcase
      end
    end

    always_comb begin
      delays[s].prop = calQ + usrQ;
      delays[s].off  = offQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rangeErr <= 1'b0;
    else       rangeErr <= rangeErr | (|errHit);
  end
endmodule

// File: rtl/eds_datapath.sv
module eds_datapath
  import eds_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  edgeStrobe_t         strobe,
  input  sigDelay_t           delays [NUM_SIG],
  input  logic [CYC_W-1:0]    evCycle,
  output logic                outValid,
  output logic                outIsEnable,
  output logic                outRise,
  output logic [TIME_W-1:0]   outTime,
  output logic [TIME_W-1:0]   outEffTime,
  output logic                outDistort
);
  localparam int WIDE_W = TIME_W + 2;
  localparam int SIG_EN = 1;

  logic [TIME_W-1:0]        lastRise [NUM_SIG];
  sigDelay_t                sel;
  logic [TIME_W-1:0]        base;
  logic [TIME_W:0]          riseWide;
  logic signed [WIDE_W-1:0] offExt;
  logic signed [WIDE_W-1:0] fallWide;
  logic signed [WIDE_W-1:0] floorWide;
  logic [TIME_W-1:0]        edgeTime;
  logic [TIME_W-1:0]        effTime;
  logic                     clampHit;

  always_comb begin
    sel       = delays[strobe.isEnable];
    base      = {evCycle, {FINE_W{1'b0}}};
    riseWide  = {1'b0, base} + {{(TIME_W+1-SET_W){1'b0}}, sel.prop};
    offExt    = {{(WIDE_W-SET_W){sel.off[SET_W-1]}}, sel.off};
    fallWide  = $signed({1'b0, riseWide}) + offExt;
    floorWide = $signed({2'b00, lastRise[strobe.isEnable]});
    clampHit  = !strobe.isRise && (fallWide < floorWide);
    if (strobe.isRise)
      edgeTime = riseWide[TIME_W-1:0];
    else if (clampHit)
      edgeTime = lastRise[strobe.isEnable];
    else
      edgeTime = fallWide[TIME_W-1:0];
    if (!strobe.isEnable && (lastRise[SIG_EN] > edgeTime))
      effTime = lastRise[SIG_EN];
    else
      effTime = edgeTime;
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN)
        lastRise[s] <= '0;
      else if (strobe.capture && strobe.isRise && (strobe.isEnable == s[0]))
        lastRise[s] <= edgeTime;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outIsEnable <= 1'b0;
      outRise     <= 1'b0;
      outTime     <= '0;
      outEffTime  <= '0;
      outDistort  <= 1'b0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outIsEnable <= strobe.isEnable;
        outRise     <= strobe.isRise;
        outTime     <= edgeTime;
        outEffTime  <= effTime;
        outDistort  <= clampHit;
      end else begin
        outDistort  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/edge_delay_scheduler.sv
module edge_delay_scheduler
  import eds_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgChan,
  input  logic [1:0]        cfgField,
  input  logic [7:0]        cfgData,
  input  logic              evValid,
  input  logic              evIsEnable,
  input  logic              evRise,
  input  logic [23:0]       evCycle,
  output logic              outValid,
  output logic              outIsEnable,
  output logic              outRise,
  output logic [31:0]       outTime,
  output logic [31:0]       outEffTime,
  output logic              outDistort,
  output logic              rangeErr
);
  edgeStrobe_t strobe;
  sigDelay_t   delays [NUM_SIG];

  eds_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgChan(cfgChan), .cfgField(cfgField), .cfgData(cfgData),
    .evValid(evValid), .evIsEnable(evIsEnable), .evRise(evRise),
    .strobe(strobe), .delays(delays), .rangeErr(rangeErr)
  );

  eds_datapath i_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .delays(delays), .evCycle(evCycle),
    .outValid(outValid), .outIsEnable(outIsEnable), .outRise(outRise),
    .outTime(outTime), .outEffTime(outEffTime), .outDistort(outDistort)
  );
endmodule

// File: rtl/eds_checker.sv
module eds_checker (
  input logic        clk,
  input logic        rstN,
  input logic        evValid,
  input logic        evIsEnable,
  input logic        evRise,
  input logic [23:0] evCycle,
  input logic        outValid,
  input logic        outIsEnable,
  input logic        outRise,
  input logic [31:0] outTime,
  input logic [31:0] outEffTime,
  input logic        outDistort,
  input logic        rangeErr
);
  // R2
  event_to_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid |=> (outValid && outIsEnable == $past(evIsEnable) && outRise == $past(evRise)));

  // R2
  idle_no_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evValid |=> !outValid);

  // R3
  rise_cycle_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evRise) |=> (outTime[31:8] == $past(evCycle) && outTime[7:0] <= 8'd240));

  // R9
  eff_not_early_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outEffTime >= outTime));

  // R9
  enable_eff_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIsEnable) |-> (outEffTime == outTime));

  // R8
  distort_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDistort |-> (outValid && !outRise));

  // R11
  range_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |=> rangeErr);
endmodule

bind edge_delay_scheduler eds_checker i_eds_checker (
  .clk(clk), .rstN(rstN),
  .evValid(evValid), .evIsEnable(evIsEnable), .evRise(evRise), .evCycle(evCycle),
  .outValid(outValid), .outIsEnable(outIsEnable), .outRise(outRise),
  .outTime(outTime), .outEffTime(outEffTime), .outDistort(outDistort),
  .rangeErr(rangeErr)
);

// File: tb/test_edge_delay_scheduler.sv
`timescale 1ns/1ps
module test_edge_delay_scheduler;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWr;
  logic        cfgChan;
  logic [1:0]  cfgField;
  logic [7:0]  cfgData;
  logic        evValid;
  logic        evIsEnable;
  logic        evRise;
  logic [23:0] evCycle;
  logic        outValid;
  logic        outIsEnable;
  logic        outRise;
  logic [31:0] outTime;
  logic [31:0] outEffTime;
  logic        outDistort;
  logic        rangeErr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  edge_delay_scheduler i_edge_delay_scheduler (.*);

  typedef struct packed {
    logic        isEn;
    logic        rise;
    logic [23:0] cyc;
    logic [31:0] expTime;
    logic [31:0] expEff;
    logic        expDist;
  } vec_t;

  // data: cal 40 + user 60 = 100, offset -50; enable: cal 20 + user 10 = 30, offset +16
  localparam vec_t TBL [9] = '{
    {1'b1, 1'b1, 24'd10,       32'd2590,       32'd2590,       1'b0},
    {1'b0, 1'b1, 24'd10,       32'd2660,       32'd2660,       1'b0},
    {1'b0, 1'b0, 24'd12,       32'd3122,       32'd3122,       1'b0},
    {1'b1, 1'b1, 24'd20,       32'd5150,       32'd5150,       1'b0},
    {1'b0, 1'b1, 24'd19,       32'd4964,       32'd5150,       1'b0},
    {1'b0, 1'b0, 24'd19,       32'd4964,       32'd5150,       1'b1},
    {1'b1, 1'b0, 24'd22,       32'd5678,       32'd5678,       1'b0},
    {1'b0, 1'b1, 24'hFFFFFF,   32'hFFFFFF64,   32'hFFFFFF64,   1'b0},
    {1'b0, 1'b0, 24'hFFFFFF,   32'hFFFFFF64,   32'hFFFFFF64,   1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic ch, input logic [1:0] fld, input logic [7:0] val,
                     input string req, input logic expErr);
    @(negedge clk);
    cfgWr = 1'b1; cfgChan = ch; cfgField = fld; cfgData = val;
    @(negedge clk);
    cfgWr = 1'b0;
    check(req, "rangeErr", 32'(rangeErr), 32'(expErr));
  endtask

  task automatic edgeEv(input logic isEn, input logic rise, input logic [23:0] cyc,
                        input logic [31:0] expT, input logic [31:0] expE,
                        input logic expD, input string req);
    @(negedge clk);
    evValid = 1'b1; evIsEnable = isEn; evRise = rise; evCycle = cyc;
    @(negedge clk);
    evValid = 1'b0;
    check("R2", "outValid", 32'(outValid), 32'd1);
    check("R2", "kind", {30'd0, outIsEnable, outRise}, {30'd0, isEn, rise});
    check(req, "outTime", outTime, expT);
    check("R9", "outEffTime", outEffTime, expE);
    check("R8", "outDistort", 32'(outDistort), 32'(expD));
    @(negedge clk);
    check("R2", "idle outValid", 32'(outValid), 32'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWr = 1'b0; cfgChan = 1'b0; cfgField = 2'd0; cfgData = '0;
    evValid = 1'b0; evIsEnable = 1'b0; evRise = 1'b0; evCycle = '0;
    doReset();
    // R1 reset state
    check("R1", "outValid", 32'(outValid), 32'd0);
    check("R1", "rangeErr", 32'(rangeErr), 32'd0);
    check("R1", "outDistort", 32'(outDistort), 32'd0);
    edgeEv(1'b0, 1'b1, 24'd3, 32'd768, 32'd768, 1'b0, "R1");

    doReset();
    // R5 separate settings per signal
    cfg(1'b0, 2'd0, 8'd40,  "R5", 1'b0);
    cfg(1'b0, 2'd1, 8'd60,  "R5", 1'b0);
    cfg(1'b0, 2'd2, 8'hCE,  "R5", 1'b0);
    cfg(1'b1, 2'd0, 8'd20,  "R5", 1'b0);
    cfg(1'b1, 2'd1, 8'd10,  "R5", 1'b0);
    cfg(1'b1, 2'd2, 8'd16,  "R5", 1'b0);
    cfg(1'b1, 2'd3, 8'd99,  "R5", 1'b0);

    // R3 R4 R8 R9 R10 table
    foreach (TBL[i]) begin
      edgeEv(TBL[i].isEn, TBL[i].rise, TBL[i].cyc, TBL[i].expTime,
             TBL[i].expEff, TBL[i].expDist, TBL[i].rise ? "R3" : "R4");
    end

    // R6 refused sum 241, old delay kept
    cfg(1'b0, 2'd1, 8'd201, "R6", 1'b1);
    edgeEv(1'b0, 1'b1, 24'd1, 32'd356, 32'd5150, 1'b0, "R6");
    // R11 flag stays while accepted writes follow; sum exactly 240 accepted
    cfg(1'b0, 2'd0, 8'd140, "R11", 1'b1);
    cfg(1'b0, 2'd1, 8'd100, "R11", 1'b1);
    edgeEv(1'b0, 1'b1, 24'd2, 32'd752, 32'd5150, 1'b0, "R6");

    // R7 offset +113 refused, old -50 kept
    cfg(1'b0, 2'd2, 8'd113, "R7", 1'b1);
    edgeEv(1'b0, 1'b0, 24'd3, 32'd958, 32'd5150, 1'b0, "R7");
    // R7 upper bound +112 accepted, R10 wrap past 2^32
    cfg(1'b0, 2'd2, 8'd112, "R7", 1'b1);
    edgeEv(1'b0, 1'b0, 24'hFFFFFF, 32'd96, 32'd5150, 1'b0, "R10");
    // R7 lower bound -128 accepted
    cfg(1'b0, 2'd2, 8'h80, "R7", 1'b1);
    edgeEv(1'b0, 1'b0, 24'd4, 32'd1136, 32'd5150, 1'b0, "R7");

    doReset();
    check("R1", "rangeErr after reset", 32'(rangeErr), 32'd0);
    check("R1", "outValid after reset", 32'(outValid), 32'd0);
    // R8 fall below time zero clamped to 0
    cfg(1'b0, 2'd2, 8'h80, "R8", 1'b0);
    edgeEv(1'b0, 1'b0, 24'd0, 32'd0, 32'd0, 1'b1, "R8");
    // R4 offset leaves rising edge untouched
    edgeEv(1'b0, 1'b1, 24'd5, 32'd1280, 32'd1280, 1'b0, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule